// File: doc/BRIEF.md
# Sector Modify-Protection Unit

This unit decides, for every program or erase request aimed at a memory sector, whether the request may proceed. It keeps one protection bit per sector. A set bit locks its sector. These volatile bits come out of reset fully set. When reset is released, the unit fetches the stored protection word once over a small configuration-memory read port and copies it into the volatile bits. After that, the bits are never reloaded.

Software can change the stored protection word only by a program request aimed at the protection location. The unit serves that request as a read-modify-write on the configuration-memory port. The value it writes is the current stored word ANDed with the low bits of the request data, so a program can only turn ones into zeros. An erase aimed at the protection location is refused. Requests that arrive while the unit is loading, or while it is updating the stored word, are refused.

The control is a four-state machine:

- `ST_LOAD` is entered on reset. It asserts the read request and moves to `ST_READY` when the read is acknowledged.
- `ST_READY` judges requests. A program to the protection location moves it to `ST_NV_READ`.
- `ST_NV_READ` waits for the read acknowledge, captures the merged word, and moves to `ST_NV_WRITE`.
- `ST_NV_WRITE` holds the write request until it is acknowledged, then returns to `ST_READY`.

Top module: `sector_guard`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy` is 1, `nv_rd_req` is 1, and `grant` and `err` are 0. The volatile protection word is all ones, so every sector is locked.
- R2: The stored protection word is read exactly once after reset, and the volatile bits take the value returned with that read. Any later read happens only as the first half of a protection-word program.
- R3: Until the initial read is acknowledged, `busy` stays 1 and every request is answered with a one-cycle `err` pulse in the cycle after it, with no `grant`.
- R4: A sector request (`req_nvp`=0) in the ready state, program (`req_op`=0) or erase (`req_op`=1), to a sector whose volatile bit is 1 produces `err`=1 and `grant`=0 in the next cycle.
- R5: A sector request in the ready state to a sector whose volatile bit is 0 produces `grant`=1 and `err`=0 in the next cycle.
- R6: An erase aimed at the protection location (`req_nvp`=1, `req_op`=1) produces `err` in the next cycle. It issues no configuration-memory read or write, and the stored word is unchanged.
- R7: A program aimed at the protection location writes the stored word ANDed with `req_data[NUM_SECTORS-1:0]`, so no bit ever goes from 0 to 1. `nv_wr_req` and `nv_wr_data` hold steady until `nv_wr_ack`.
- R8: While a protection-word program is in progress, `busy` is 1 and every request is refused with `err`. One `grant` pulse marks completion in the cycle after `nv_wr_ack`.
- R9: A protection-word program does not alter the volatile bits. A sector whose stored bit was cleared stays locked until the next reset.
- R10: Bits of `req_data` at positions `NUM_SECTORS` and above have no effect on the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 1 | 0 = program, 1 = erase |
| req_nvp | input | 1 | 1 = request aims at the stored protection location |
| req_sector | input | SECT_W | Target sector index when `req_nvp`=0 |
| req_data | input | DATA_W | Double-word program data; the low `NUM_SECTORS` bits are used |
| grant | output | 1 | One-cycle pulse: request allowed, or protection program finished |
| err | output | 1 | One-cycle pulse: request refused |
| busy | output | 1 | Loading or updating the stored word |
| nv_rd_req | output | 1 | Configuration-memory read request, held until acknowledged |
| nv_rd_ack | input | 1 | Read acknowledge, one cycle |
| nv_rd_data | input | NUM_SECTORS | Stored protection word, valid with `nv_rd_ack` |
| nv_wr_req | output | 1 | Configuration-memory write request, held until acknowledged |
| nv_wr_data | output | NUM_SECTORS | Word to write |
| nv_wr_ack | input | 1 | Write acknowledge, one cycle |

## Verification
The bench builds the unit with its defaults: 32 sectors and 64-bit request data. With these values, one request to each index covers every volatile bit, and the upper half of the program data can carry a non-zero pattern that must not reach the written word. The bench's storage model answers after a three-cycle latency. That latency leaves room to send requests in the middle of both the initial load and a read-modify-write.

// File: rtl/sg_pkg.sv
package sg_pkg;

    // Control states of the protection unit
    typedef enum logic [1:0] {
        ST_LOAD     = 2'd0,
        ST_READY    = 2'd1,
        ST_NV_READ  = 2'd2,
        ST_NV_WRITE = 2'd3
    } sg_state_t;

    // Request kind carried on req_op
    typedef enum logic {
        OP_PROGRAM = 1'b0,
        OP_ERASE   = 1'b1
    } sg_op_t;

    // Outcome of judging one request
    typedef enum logic [1:0] {
        V_NONE  = 2'd0,
        V_ALLOW = 2'd1,
        V_DENY  = 2'd2
    } sg_verdict_t;

endpackage

// File: rtl/sg_prot_bank.sv
// Volatile per-sector lock bits: reset to locked, loaded once on request.
module sg_prot_bank #(
    parameter int NUM_SECTORS = 32,
    parameter int SECT_W      = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_en,
    input  logic [NUM_SECTORS-1:0] load_word,
    input  logic [SECT_W-1:0]      sector,
    output logic                   locked
);

    logic [NUM_SECTORS-1:0] lock_q;

    // One flop per sector, each forced to the locked value by reset
    for (genvar g = 0; g < NUM_SECTORS; g++) begin : g_lock
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lock_q[g] <= 1'b1;
            end else if (load_en) begin
                lock_q[g] <= load_word[g];
            end
        end
    end

    // Indices without a sector behind them read as locked
    always_comb begin
        locked = 1'b1;
        for (int i = 0; i < NUM_SECTORS; i++) begin
            if (sector == SECT_W'(i)) begin
                locked = lock_q[i];
            end
        end
    end

endmodule

// File: rtl/sg_nv_merge.sv
// Holds the pending program pattern and builds the clear-only write word.
module sg_nv_merge #(
    parameter int NUM_SECTORS = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pend_capture,
    input  logic [NUM_SECTORS-1:0] pend_word,
    input  logic                   merge_capture,
    input  logic [NUM_SECTORS-1:0] stored_word,
    output logic [NUM_SECTORS-1:0] write_word
);

    logic [NUM_SECTORS-1:0] pend_q;
    logic [NUM_SECTORS-1:0] merge_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '1;
        end else if (pend_capture) begin
            pend_q <= pend_word;
        end
    end

    // Programming can only pull bits low: AND with what is stored now
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            merge_q <= '1;
        end else if (merge_capture) begin
            merge_q <= stored_word & pend_q;
        end
    end

    assign write_word = merge_q;

endmodule

// File: rtl/sg_fsm.sv
// Control state machine: initial load, request judging, protection-word update.
module sg_fsm
    import sg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_valid,
    input  logic      req_op,
    input  logic      req_nvp,
    input  logic      sector_locked,
    input  logic      nv_rd_ack,
    input  logic      nv_wr_ack,
    output logic      busy,
    output logic      nv_rd_req,
    output logic      nv_wr_req,
    output logic      vol_load,
    output logic      pend_capture,
    output logic      merge_capture,
    output logic      grant,
    output logic      err
);

    sg_state_t   state_q, state_d;
    sg_verdict_t verdict;
    logic        write_done;
    logic        grant_d, err_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD: begin
                if (nv_rd_ack) state_d = ST_READY;
            end
            ST_READY: begin
                if (req_valid && req_nvp && sg_op_t'(req_op) == OP_PROGRAM) begin
                    state_d = ST_NV_READ;
                end
            end
            ST_NV_READ: begin
                if (nv_rd_ack) state_d = ST_NV_WRITE;
            end
            ST_NV_WRITE: begin
                if (nv_wr_ack) state_d = ST_READY;
            end
            default: state_d = ST_LOAD;
        endcase
    end

    // Request judgement: only the ready state can allow anything
    always_comb begin
        verdict = V_NONE;
        if (req_valid) begin
            unique case (state_q)
                ST_READY: begin
                    if (req_nvp) begin
                        verdict = (sg_op_t'(req_op) == OP_ERASE) ? V_DENY : V_NONE;
                    end else begin
                        verdict = sector_locked ? V_DENY : V_ALLOW;
                    end
                end
                default: verdict = V_DENY;
            endcase
        end
    end

    // Outputs decoded from the state and handshakes
    always_comb begin
        busy          = 1'b1;
        nv_rd_req     = 1'b0;
        nv_wr_req     = 1'b0;
        vol_load      = 1'b0;
        pend_capture  = 1'b0;
        merge_capture = 1'b0;
        write_done    = 1'b0;
        unique case (state_q)
            ST_LOAD: begin
                nv_rd_req = 1'b1;
                vol_load  = nv_rd_ack;
            end
            ST_READY: begin
                busy         = 1'b0;
                pend_capture = req_valid && req_nvp && sg_op_t'(req_op) == OP_PROGRAM;
            end
            ST_NV_READ: begin
                nv_rd_req     = 1'b1;
                merge_capture = nv_rd_ack;
            end
            ST_NV_WRITE: begin
                nv_wr_req  = 1'b1;
                write_done = nv_wr_ack;
            end
            default: begin
                busy = 1'b1;
            end
        endcase
        grant_d = (verdict == V_ALLOW) || write_done;
        err_d   = (verdict == V_DENY);
    end

    // Registered one-cycle response pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant <= 1'b0;
            err   <= 1'b0;
        end else begin
            grant <= grant_d;
            err   <= err_d;
        end
    end

endmodule

// File: rtl/sector_guard.sv
// Sector modify-protection unit top level.
module sector_guard #(
    parameter int NUM_SECTORS = 32,
    parameter int DATA_W      = 64,
    parameter int SECT_W      = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_op,
    input  logic                   req_nvp,
    input  logic [SECT_W-1:0]      req_sector,
    input  logic [DATA_W-1:0]      req_data,
    output logic                   grant,
    output logic                   err,
    output logic                   busy,
    output logic                   nv_rd_req,
    input  logic                   nv_rd_ack,
    input  logic [NUM_SECTORS-1:0] nv_rd_data,
    output logic                   nv_wr_req,
    output logic [NUM_SECTORS-1:0] nv_wr_data,
    input  logic                   nv_wr_ack
);

    localparam int HI_W = DATA_W - NUM_SECTORS;

    logic sector_locked;
    logic vol_load;
    logic pend_capture;
    logic merge_capture;

    // Upper data bits carry nothing for this unit
    if (HI_W > 0) begin : g_hi
        logic unused_hi;
        assign unused_hi = ^req_data[DATA_W-1:NUM_SECTORS];
    end

    sg_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_op        (req_op),
        .req_nvp       (req_nvp),
        .sector_locked (sector_locked),
        .nv_rd_ack     (nv_rd_ack),
        .nv_wr_ack     (nv_wr_ack),
        .busy          (busy),
        .nv_rd_req     (nv_rd_req),
        .nv_wr_req     (nv_wr_req),
        .vol_load      (vol_load),
        .pend_capture  (pend_capture),
        .merge_capture (merge_capture),
        .grant         (grant),
        .err           (err)
    );

    sg_prot_bank #(
        .NUM_SECTORS (NUM_SECTORS),
        .SECT_W      (SECT_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (vol_load),
        .load_word (nv_rd_data),
        .sector    (req_sector),
        .locked    (sector_locked)
    );

    sg_nv_merge #(
        .NUM_SECTORS (NUM_SECTORS)
    ) u_merge (
        .clk           (clk),
        .rst_n         (rst_n),
        .pend_capture  (pend_capture),
        .pend_word     (req_data[NUM_SECTORS-1:0]),
        .merge_capture (merge_capture),
        .stored_word   (nv_rd_data),
        .write_word    (nv_wr_data)
    );

endmodule

// File: rtl/sg_checker.sv
// Temporal checks on the protection unit, attached by bind.
module sg_checker #(
    parameter int NUM_SECTORS = 32,
    parameter int SECT_W      = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic                   req_op,
    input logic                   req_nvp,
    input logic [SECT_W-1:0]      req_sector,
    input logic                   grant,
    input logic                   err,
    input logic                   busy,
    input logic                   nv_rd_req,
    input logic                   nv_rd_ack,
    input logic [NUM_SECTORS-1:0] nv_rd_data,
    input logic                   nv_wr_req,
    input logic [NUM_SECTORS-1:0] nv_wr_data,
    input logic                   nv_wr_ack
);

    logic                   loaded;
    logic [NUM_SECTORS-1:0] lock_seen;
    logic [NUM_SECTORS-1:0] last_read;

    // Observe the handshake to learn the first loaded word and the latest read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            loaded    <= 1'b0;
            lock_seen <= '1;
            last_read <= '1;
        end else if (nv_rd_req && nv_rd_ack) begin
            last_read <= nv_rd_data;
            if (!loaded) begin
                loaded    <= 1'b1;
                lock_seen <= nv_rd_data;
            end
        end
    end

    AST_BUSY_BEFORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !loaded |-> busy); // R3
    AST_NO_GRANT_BEFORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !loaded |-> !grant); // R3
    AST_READ_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        nv_rd_req |-> busy); // R2
    AST_LOCKED_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_nvp && !busy && lock_seen[req_sector]) |=> (err && !grant)); // R4
    AST_OPEN_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_nvp && !busy && !lock_seen[req_sector]) |=> (grant && !err)); // R5
    AST_NVP_ERASE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_nvp && req_op && !busy) |=> (err && !busy && !nv_wr_req && !nv_rd_req)); // R6
    AST_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        nv_wr_req |-> ((nv_wr_data & ~last_read) == '0)); // R7
    AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_wr_req && !nv_wr_ack) |=> (nv_wr_req && $stable(nv_wr_data))); // R7

endmodule

bind sector_guard sg_checker #(
    .NUM_SECTORS (NUM_SECTORS),
    .SECT_W      (SECT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_nvp    (req_nvp),
    .req_sector (req_sector),
    .grant      (grant),
    .err        (err),
    .busy       (busy),
    .nv_rd_req  (nv_rd_req),
    .nv_rd_ack  (nv_rd_ack),
    .nv_rd_data (nv_rd_data),
    .nv_wr_req  (nv_wr_req),
    .nv_wr_data (nv_wr_data),
    .nv_wr_ack  (nv_wr_ack)
);

// File: tb/sector_guard_tb.sv
`timescale 1ns/1ps
module sector_guard_tb;

    localparam int NS     = 32;
    localparam int DW     = 64;
    localparam int SW     = 5;
    localparam int NV_LAT = 3;
    localparam logic [NS-1:0] INIT_WORD = 32'h0F0F_00F3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_op = 1'b0;
    logic          req_nvp = 1'b0;
    logic [SW-1:0] req_sector = '0;
    logic [DW-1:0] req_data = '0;
    logic          grant, err, busy;
    logic          nv_rd_req, nv_wr_req;
    logic          nv_rd_ack = 1'b0;
    logic          nv_wr_ack = 1'b0;
    logic [NS-1:0] nv_rd_data = '0;
    logic [NS-1:0] nv_wr_data;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    sector_guard #(.NUM_SECTORS(NS), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_nvp(req_nvp), .req_sector(req_sector), .req_data(req_data),
        .grant(grant), .err(err), .busy(busy), .nv_rd_req(nv_rd_req),
        .nv_rd_ack(nv_rd_ack), .nv_rd_data(nv_rd_data), .nv_wr_req(nv_wr_req),
        .nv_wr_data(nv_wr_data), .nv_wr_ack(nv_wr_ack)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Storage model: answers a held request after NV_LAT cycles
    logic [NS-1:0] nv_mem = INIT_WORD;
    int nv_cnt = 0;
    int n_reads = 0;
    int n_writes = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            nv_rd_ack = 1'b0; nv_wr_ack = 1'b0; nv_cnt = 0;
        end else if (nv_rd_ack || nv_wr_ack) begin
            nv_rd_ack = 1'b0; nv_wr_ack = 1'b0; nv_cnt = 0;
        end else if (nv_rd_req || nv_wr_req) begin
            nv_cnt++;
            if (nv_cnt >= NV_LAT) begin
                if (nv_wr_req) begin
                    nv_mem = nv_wr_data; nv_wr_ack = 1'b1; n_writes++;
                end else begin
                    nv_rd_data = nv_mem; nv_rd_ack = 1'b1; n_reads++;
                end
            end
        end
    end

    // Behavioural reference: phase 0 load, 1 ready, 2 fetch, 3 store
    int            m_phase = 0;
    logic [NS-1:0] m_lock = '1;
    logic [NS-1:0] m_pend = '0;
    logic [NS-1:0] m_word = '0;
    logic          m_grant = 1'b0;
    logic          m_err = 1'b0;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_lock = '1; m_grant = 1'b0; m_err = 1'b0;
        end else begin
            m_grant = 1'b0; m_err = 1'b0;
            if (m_phase == 1) begin
                if (req_valid) begin
                    if (req_nvp) begin
                        if (req_op) m_err = 1'b1;
                        else begin m_pend = req_data[NS-1:0]; m_phase = 2; end
                    end else if (m_lock[req_sector]) m_err = 1'b1;
                    else m_grant = 1'b1;
                end
            end else begin
                if (req_valid) m_err = 1'b1;
                if (m_phase == 0 && nv_rd_ack) begin m_lock = nv_rd_data; m_phase = 1; end
                else if (m_phase == 2 && nv_rd_ack) begin m_word = nv_rd_data & m_pend; m_phase = 3; end
                else if (m_phase == 3 && nv_wr_ack) begin m_grant = 1'b1; m_phase = 1; end
            end
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(busy == (m_phase != 1), "R3 busy", busy, m_phase != 1);
            check(err == m_err, "R4 err", err, m_err);
            check(grant == m_grant, "R5 grant", grant, m_grant);
            check(nv_rd_req == (m_phase == 0 || m_phase == 2), "R2 nv_rd_req", nv_rd_req, m_phase);
            check(nv_wr_req == (m_phase == 3), "R8 nv_wr_req", nv_wr_req, m_phase == 3);
            if (m_phase == 3) check(nv_wr_data == m_word, "R7 nv_wr_data", nv_wr_data, m_word);
        end
    end

    task automatic issue(input logic op, input logic nvp, input int sec, input logic [DW-1:0] d,
                         output logic g, output logic e);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_nvp = nvp; req_sector = SW'(sec); req_data = d;
        @(negedge clk);
        req_valid = 1'b0; g = grant; e = err;
    endtask

    task automatic wait_idle(output logic g_at_end);
        g_at_end = 1'b0;
        while (busy) @(negedge clk);
        g_at_end = grant;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic g, e, gend;
        logic [NS-1:0] after_prog;
        repeat (3) @(negedge clk);
        // R1: state during reset
        check(busy == 1'b1 && nv_rd_req == 1'b1, "R1 reset busy/rd_req", {busy, nv_rd_req}, 2'b11);
        check(grant == 1'b0 && err == 1'b0, "R1 reset grant/err", {grant, err}, 2'b00);
        rst_n = 1'b1;
        // R3: request during the initial load is refused
        issue(1'b0, 1'b0, 2, '0, g, e);
        check(e == 1'b1 && g == 1'b0, "R3 request during load", {g, e}, 2'b01);
        wait_idle(gend);
        // R2: exactly one read so far
        check(n_reads == 1, "R2 single load read", n_reads, 1);
        // R5 / R4 on the loaded pattern
        issue(1'b0, 1'b0, 2, '0, g, e);
        check(g == 1'b1 && e == 1'b0, "R5 program open sector 2", {g, e}, 2'b10);
        issue(1'b0, 1'b0, 0, '0, g, e);
        check(g == 1'b0 && e == 1'b1, "R4 program locked sector 0", {g, e}, 2'b01);
        issue(1'b1, 1'b0, 8, '0, g, e);
        check(g == 1'b1 && e == 1'b0, "R5 erase open sector 8", {g, e}, 2'b10);
        issue(1'b1, 1'b0, 17, '0, g, e);
        check(g == 1'b0 && e == 1'b1, "R4 erase locked sector 17", {g, e}, 2'b01);
        // R6: erase of the protection location
        issue(1'b1, 1'b1, 0, '0, g, e);
        check(e == 1'b1 && g == 1'b0, "R6 protection erase refused", {g, e}, 2'b01);
        repeat (5) @(negedge clk);
        check(nv_mem == INIT_WORD && n_writes == 0, "R6 stored word untouched", nv_mem, INIT_WORD);
        // R7 / R10: program with junk in the upper half
        issue(1'b0, 1'b1, 0, {32'h1234_5678, 32'hF0FF_FF0F}, g, e);
        check(busy == 1'b1, "R8 busy during program", busy, 1);
        issue(1'b0, 1'b0, 2, '0, g, e);
        check(e == 1'b1 && g == 1'b0, "R8 request during program", {g, e}, 2'b01);
        wait_idle(gend);
        check(gend == 1'b1, "R8 completion grant", gend, 1);
        after_prog = INIT_WORD & 32'hF0FF_FF0F;
        check(nv_mem == after_prog, "R7 R10 clear-only write", nv_mem, after_prog);
        check(n_reads == 2, "R2 reads after one program", n_reads, 2);
        // R9: volatile bits keep the loaded value
        issue(1'b0, 1'b0, 24, '0, g, e);
        check(e == 1'b1 && g == 1'b0, "R9 sector 24 stays locked", {g, e}, 2'b01);
        issue(1'b1, 1'b0, 4, '0, g, e);
        check(e == 1'b1 && g == 1'b0, "R9 sector 4 stays locked", {g, e}, 2'b01);
        // R7: programming ones cannot set cleared bits
        issue(1'b0, 1'b1, 0, '1, g, e);
        wait_idle(gend);
        check(nv_mem == after_prog, "R7 ones cannot be set", nv_mem, after_prog);
        // R4 / R5: every sector, alternating program and erase
        for (int s = 0; s < NS; s++) begin
            issue(logic'(s % 2), 1'b0, s, '0, g, e);
            check(e == INIT_WORD[s] && g == !INIT_WORD[s], "R4 R5 sector sweep", {g, e}, {!INIT_WORD[s], INIT_WORD[s]});
        end
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule